// File: doc/BRIEF.md
# Segmented Data Memory Addressing Unit

This block sits between the decode stage of an 8-bit microcontroller and its data RAM. For each access request it forms a logical byte address, either taken directly from the request or from one of two indirect pointers, and turns that logical address into a 15-bit physical RAM address. Logical addresses in the lower half of the space are placed in one of 256 segments of 128 bytes, chosen by an 8-bit segment register. Logical addresses in the upper half always reach one common page and ignore the segment register.

The block holds four state bytes: two indirect pointers, a stack pointer and the segment register. They appear as data bytes at the top of the common page, so ordinary reads, writes and bit operations reach them without a separate access path. After an indirect access, the pointer that was used can be stepped up or down by one. The block also carries out the data side of read-modify-write operations on any byte: decrement with a zero test, bit set, bit clear and bit test. It takes the old value from RAM, or from its own register when the address is mapped, and drives the new value back.

Address, write strobe, write data, read data and flag are all combinational from the request in the same cycle. Register updates take effect at the next rising clock edge.

Top module: `dmem_addr_unit`

## Requirements
- R1: After reset the B pointer, the X pointer and the segment register read 0x00, and the stack pointer reads RAM_BYTES-17 (0x6F for 128 bytes, 0x2F for 64 bytes).
- R2: A logical address below 0x80 drives mem_addr = {S, addr[6:0]}, where S is the segment register value.
- R3: A logical address of 0x80 or above drives mem_addr = {7'h0, addr}, whatever S holds.
- R4: With req_indirect=1 the logical address is B when req_ptr=0 and X when req_ptr=1. Setting req_post to 1 increments the pointer used and 2 decrements it, modulo 256, and the new value is visible from the next cycle. req_post=0 or 3 leaves the pointer unchanged.
- R5: Logical 0xFC is X, 0xFD is SP, 0xFE is B and 0xFF is S. An access to these addresses reads the register, writes it at the next edge and keeps mem_we low. If a mapped write and a post-update hit the same pointer in one cycle, the written value is kept.
- R6: Op encoding is 0 read, 1 write, 2 decrement-test, 3 bit set, 4 bit clear, 5 bit test. A write to an unmapped address raises mem_we with mem_wdata = req_wdata. rsp_rdata returns mem_rdata for unmapped addresses.
- R7: Decrement-test (op 2) writes old-1 modulo 256 and sets rsp_flag exactly when that result is zero. On a mapped address it decrements the register.
- R8: Bit set (op 3) and bit clear (op 4) write the old value with bit req_bit forced to 1 or 0.
- R9: Bit test (op 5) drives rsp_flag = old[req_bit] and writes nothing.
- R10: While req_valid is 0, mem_we stays low and no register changes, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R6) |
| req_indirect | input | 1 | 1 selects pointer addressing |
| req_ptr | input | 1 | Pointer select: 0 B, 1 X |
| req_post | input | 2 | Post-update: 0 none, 1 increment, 2 decrement |
| req_addr | input | 8 | Direct logical address |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Write data for op 1 |
| mem_rdata | input | 8 | Byte read from RAM at mem_addr |
| mem_addr | output | 15 | Physical RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| rsp_rdata | output | 8 | Old value of the addressed byte |
| rsp_flag | output | 1 | Zero result (op 2) or tested bit (op 5) |

## Verification
mem_addr, mem_we, mem_wdata, rsp_rdata and rsp_flag are due in the same cycle as the request, with no register on the path. Changes to the pointers, stack pointer and segment register take effect at the first rising edge after the request. The bench drives each request on a falling edge and compares the combinational outputs 5 ns later, before the next rising edge. Its reference state steps only after that comparison, so a post-update or mapped write shows up in the next request's expected values. Register contents are observed at the ports by reading the mapped addresses 0xFC to 0xFF.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_DECT  = 3'd2,
        OP_BSET  = 3'd3,
        OP_BCLR  = 3'd4,
        OP_BTST  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        PU_NONE = 2'd0,
        PU_INC  = 2'd1,
        PU_DEC  = 2'd2,
        PU_RSVD = 2'd3
    } post_e;

    // index of a mapped register within the top four bytes of the common page
    typedef enum logic [1:0] {
        MI_X  = 2'd0,
        MI_SP = 2'd1,
        MI_B  = 2'd2,
        MI_S  = 2'd3
    } map_idx_e;

endpackage

// File: rtl/dmau_addr_gen.sv
module dmau_addr_gen #(
    parameter int DATA_W = 8,
    localparam int PHYS_W = 2 * DATA_W - 1
) (
    input  logic              indirect,
    input  logic              ptr_sel,
    input  logic [DATA_W-1:0] dir_addr,
    input  logic [DATA_W-1:0] b_val,
    input  logic [DATA_W-1:0] x_val,
    input  logic [DATA_W-1:0] seg_val,
    output logic [DATA_W-1:0] logical,
    output logic [PHYS_W-1:0] phys,
    output logic              map_hit,
    output logic [1:0]        map_idx
);

    always_comb begin
        if (indirect) begin
            logical = ptr_sel ? x_val : b_val;
        end else begin
            logical = dir_addr;
        end

        if (logical[DATA_W-1]) begin
            phys = {{(DATA_W-1){1'b0}}, logical};
        end else begin
            phys = {seg_val, logical[DATA_W-2:0]};
        end

        map_hit = &logical[DATA_W-1:2];
        map_idx = logical[1:0];
    end

endmodule

// File: rtl/dmau_modify.sv
module dmau_modify
    import dmau_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  op_e               op,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write,
    output logic              flag
);

    logic [DATA_W-1:0] bit_mask;

    always_comb begin
        bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
        new_val  = old_val;
        do_write = 1'b0;
        flag     = 1'b0;
        case (op)
            OP_WRITE: begin
                new_val  = wr_val;
                do_write = 1'b1;
            end
            OP_DECT: begin
                new_val  = old_val - 1'b1;
                do_write = 1'b1;
                flag     = (new_val == '0);
            end
            OP_BSET: begin
                new_val  = old_val | bit_mask;
                do_write = 1'b1;
            end
            OP_BCLR: begin
                new_val  = old_val & ~bit_mask;
                do_write = 1'b1;
            end
            OP_BTST: begin
                flag = old_val[bit_idx];
            end
            default: begin
                new_val = old_val;
            end
        endcase
    end

endmodule

// File: rtl/dmau_regs.sv
module dmau_regs
    import dmau_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  SP_RST = 8'h6F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_ptr,
    input  logic              upd_inc,
    input  logic              wr_map,
    input  logic [1:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] b_q,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] s_q
);

    localparam int NPTR = 2;

    typedef struct packed {
        logic [NPTR-1:0][DATA_W-1:0] ptr;   // [0] = B, [1] = X
        logic [DATA_W-1:0]           sp;
        logic [DATA_W-1:0]           seg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPTR; i++) begin
            if (upd_en && (upd_ptr == i[0])) begin
                st_d.ptr[i] = upd_inc ? st_q.ptr[i] + 1'b1 : st_q.ptr[i] - 1'b1;
            end
        end
        if (wr_map) begin
            case (map_idx_e'(wr_idx))
                MI_X:    st_d.ptr[1] = wr_val;
                MI_SP:   st_d.sp     = wr_val;
                MI_B:    st_d.ptr[0] = wr_val;
                default: st_d.seg    = wr_val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr <= '0;
            st_q.sp  <= SP_RST[DATA_W-1:0];
            st_q.seg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign b_q  = st_q.ptr[0];
    assign x_q  = st_q.ptr[1];
    assign sp_q = st_q.sp;
    assign s_q  = st_q.seg;

    AST_B_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_ptr && upd_inc && !(wr_map && wr_idx == 2'd2))
        |=> (st_q.ptr[0] == $past(st_q.ptr[0]) + 1'b1)); // R4

    AST_X_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_ptr && !upd_inc && !(wr_map && wr_idx == 2'd0))
        |=> (st_q.ptr[1] == $past(st_q.ptr[1]) - 1'b1)); // R4

    AST_WRITE_WINS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_map && wr_idx == 2'd2) |=> (b_q == $past(wr_val))); // R5

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_map && wr_idx == 2'd1) |=> $stable(sp_q)); // R10

endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
    import dmau_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RAM_BYTES = 128,
    localparam int PHYS_W   = 2 * DATA_W - 1,
    localparam int BIT_W    = $clog2(DATA_W),
    localparam logic [7:0] SP_RST = 8'(RAM_BYTES - 17)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_indirect,
    input  logic              req_ptr,
    input  logic [1:0]        req_post,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [BIT_W-1:0]  req_bit,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_flag
);

    logic [DATA_W-1:0] b_q, x_q, sp_q, s_q;
    logic [DATA_W-1:0] logical, reg_val, old_val, new_val;
    logic              map_hit, do_write;
    logic [1:0]        map_idx;
    logic              upd_en, upd_inc, wr_map;
    op_e               op;
    post_e             post;

    assign op   = op_e'(req_op);
    assign post = post_e'(req_post);

    dmau_addr_gen #(.DATA_W(DATA_W)) u_addr (
        .indirect (req_indirect),
        .ptr_sel  (req_ptr),
        .dir_addr (req_addr),
        .b_val    (b_q),
        .x_val    (x_q),
        .seg_val  (s_q),
        .logical  (logical),
        .phys     (mem_addr),
        .map_hit  (map_hit),
        .map_idx  (map_idx)
    );

    always_comb begin
        case (map_idx_e'(map_idx))
            MI_X:    reg_val = x_q;
            MI_SP:   reg_val = sp_q;
            MI_B:    reg_val = b_q;
            default: reg_val = s_q;
        endcase
        old_val = map_hit ? reg_val : mem_rdata;
    end

    dmau_modify #(.DATA_W(DATA_W)) u_mod (
        .op       (op),
        .bit_idx  (req_bit),
        .old_val  (old_val),
        .wr_val   (req_wdata),
        .new_val  (new_val),
        .do_write (do_write),
        .flag     (rsp_flag)
    );

    assign upd_en  = req_valid && req_indirect && (post == PU_INC || post == PU_DEC);
    assign upd_inc = (post == PU_INC);
    assign wr_map  = req_valid && do_write && map_hit;

    dmau_regs #(.DATA_W(DATA_W), .SP_RST(SP_RST)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_ptr (req_ptr),
        .upd_inc (upd_inc),
        .wr_map  (wr_map),
        .wr_idx  (map_idx),
        .wr_val  (new_val),
        .b_q     (b_q),
        .x_q     (x_q),
        .sp_q    (sp_q),
        .s_q     (s_q)
    );

    assign mem_we    = req_valid && do_write && !map_hit;
    assign mem_wdata = new_val;
    assign rsp_rdata = old_val;

    AST_NO_RAM_WE_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !map_hit); // R5

    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !mem_we); // R10

    AST_DEC_ZERO_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_DECT && rsp_flag) |-> (rsp_rdata == 1)); // R7

    AST_BTST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_BTST) |-> !mem_we); // R9

endmodule

// File: tb/test_dmem_addr_unit.sv
module test_dmem_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic        req_indirect = 1'b0;
    logic        req_ptr = 1'b0;
    logic [1:0]  req_post = 2'd0;
    logic [7:0]  req_addr = 8'h00;
    logic [2:0]  req_bit = 3'd0;
    logic [7:0]  req_wdata = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic [14:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  rsp_rdata;
    logic        rsp_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int m_b, m_x, m_sp, m_s;

    always #10 clk = ~clk;

    dmem_addr_unit i_dmem_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_indirect(req_indirect), .req_ptr(req_ptr), .req_post(req_post),
        .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .rsp_rdata(rsp_rdata), .rsp_flag(rsp_flag)
    );

    function automatic int reg_of(int la);
        case (la)
            252: return m_x;
            253: return m_sp;
            254: return m_b;
            default: return m_s;
        endcase
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic vec(string tag, bit v, int op, bit ind, bit ptr, int post,
                       int addr, int bitn, int wd, int mr);
        int la, old, nv, ph, fl;
        bit wr, hit;
        @(negedge clk);
        req_valid = v; req_op = op[2:0]; req_indirect = ind; req_ptr = ptr;
        req_post = post[1:0]; req_addr = addr[7:0]; req_bit = bitn[2:0];
        req_wdata = wd[7:0]; mem_rdata = mr[7:0];
        #5;
        la  = ind ? (ptr ? m_x : m_b) : addr;
        hit = (la >= 252);
        old = hit ? reg_of(la) : mr;
        ph  = (la >= 128) ? la : (m_s * 128 + (la % 128));
        wr = 1; nv = old; fl = 0;
        case (op)
            1: nv = wd;
            2: begin nv = (old + 255) % 256; fl = (nv == 0); end
            3: nv = old | (1 << bitn);
            4: nv = old & ~(1 << bitn) & 255;
            5: begin wr = 0; fl = (old >> bitn) & 1; end
            default: wr = 0;
        endcase
        n_vec++;
        cmp(tag, "mem_we", mem_we, (v && wr && !hit));
        if (v) begin
            cmp(tag, "mem_addr", mem_addr, ph);
            cmp(tag, "rsp_rdata", rsp_rdata, old);
            cmp(tag, "rsp_flag", rsp_flag, fl);
            if (wr && !hit) cmp(tag, "mem_wdata", mem_wdata, nv);
        end
        // next state of the reference, taking effect at the coming rising edge
        if (v && ind && (post == 1 || post == 2)) begin
            if (ptr) m_x = (post == 1) ? (m_x + 1) % 256 : (m_x + 255) % 256;
            else     m_b = (post == 1) ? (m_b + 1) % 256 : (m_b + 255) % 256;
        end
        if (v && wr && hit) begin
            case (la)
                252: m_x = nv;
                253: m_sp = nv;
                254: m_b = nv;
                default: m_s = nv;
            endcase
        end
    endtask

    task automatic rd(string tag, int addr);
        vec(tag, 1, 0, 0, 0, 0, addr, 0, 0, 8'h5A);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_b = 0; m_x = 0; m_s = 0; m_sp = 8'h6F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents of the mapped registers
        rd("R1", 8'hFC); rd("R1", 8'hFD); rd("R1", 8'hFE); rd("R1", 8'hFF);

        // R2 with S = 0, then load S, B, X through the mapped bytes (R5)
        rd("R2", 8'h23);
        vec("R5", 1, 1, 0, 0, 0, 8'hFF, 0, 8'h05, 8'h00);
        vec("R5", 1, 1, 0, 0, 0, 8'hFE, 0, 8'h10, 8'h00);
        vec("R5", 1, 1, 0, 0, 0, 8'hFC, 0, 8'h7E, 8'h00);
        rd("R5", 8'hFF); rd("R5", 8'hFE); rd("R5", 8'hFC);
        vec("R5", 1, 1, 0, 0, 0, 8'hFD, 0, 8'h40, 8'h00);
        rd("R5", 8'hFD);

        // R2: segmented lower half
        rd("R2", 8'h23);
        rd("R2", 8'h7F);
        vec("R2", 1, 1, 0, 0, 0, 8'h00, 0, 8'hC3, 8'h11);

        // R3: common upper half, S ignored
        rd("R3", 8'h80);
        rd("R3", 8'hC5);
        vec("R3", 1, 1, 0, 0, 0, 8'hF3, 0, 8'h99, 8'h00);

        // R6: unmapped write and read data path
        vec("R6", 1, 1, 0, 0, 0, 8'h90, 0, 8'hA5, 8'h3C);
        vec("R6", 1, 0, 0, 0, 0, 8'h91, 0, 8'h00, 8'hE7);

        // R4: indirect with post-update
        vec("R4", 1, 0, 1, 0, 1, 0, 0, 0, 8'h01);
        vec("R4", 1, 0, 1, 0, 1, 0, 0, 0, 8'h02);
        vec("R4", 1, 1, 1, 1, 2, 0, 0, 8'h33, 8'h00);
        vec("R4", 1, 0, 1, 1, 2, 0, 0, 0, 8'h04);
        vec("R4", 1, 0, 1, 1, 0, 0, 0, 0, 8'h05);
        vec("R4", 1, 0, 1, 0, 3, 0, 0, 0, 8'h06);
        rd("R4", 8'hFE); rd("R4", 8'hFC);
        // wrap both directions
        vec("R4", 1, 1, 0, 0, 0, 8'hFE, 0, 8'hFF, 8'h00);
        vec("R4", 1, 0, 1, 0, 1, 0, 0, 0, 8'h07);
        rd("R4", 8'hFE);
        vec("R4", 1, 1, 0, 0, 0, 8'hFC, 0, 8'h00, 8'h00);
        vec("R4", 1, 0, 1, 1, 2, 0, 0, 0, 8'h08);
        rd("R4", 8'hFC);

        // R5: explicit write wins over post-update of the same pointer
        vec("R5", 1, 1, 0, 0, 0, 8'hFE, 0, 8'hFE, 8'h00);
        vec("R5", 1, 1, 1, 0, 1, 0, 0, 8'h40, 8'h00);
        rd("R5", 8'hFE);
        // write B through X while X post-increments
        vec("R5", 1, 1, 0, 0, 0, 8'hFC, 0, 8'hFE, 8'h00);
        vec("R5", 1, 1, 1, 1, 1, 0, 0, 8'h61, 8'h00);
        rd("R5", 8'hFE); rd("R5", 8'hFC);

        // R7: decrement and test
        vec("R7", 1, 2, 0, 0, 0, 8'hF3, 0, 0, 8'h01);
        vec("R7", 1, 2, 0, 0, 0, 8'hF3, 0, 0, 8'h00);
        vec("R7", 1, 2, 0, 0, 0, 8'h20, 0, 0, 8'h80);
        vec("R7", 1, 1, 0, 0, 0, 8'hFC, 0, 8'h02, 8'h00);
        vec("R7", 1, 2, 0, 0, 0, 8'hFC, 0, 0, 8'h00);
        vec("R7", 1, 2, 0, 0, 0, 8'hFC, 0, 0, 8'h00);
        rd("R7", 8'hFC);

        // R8: bit set / clear
        vec("R8", 1, 3, 0, 0, 0, 8'h44, 6, 0, 8'h01);
        vec("R8", 1, 4, 0, 0, 0, 8'hA0, 0, 0, 8'hFF);
        vec("R8", 1, 3, 0, 0, 0, 8'hFD, 7, 0, 8'h00);
        vec("R8", 1, 4, 0, 0, 0, 8'hFD, 6, 0, 8'h00);
        rd("R8", 8'hFD);

        // R9: bit test
        vec("R9", 1, 5, 0, 0, 0, 8'h12, 3, 0, 8'h08);
        vec("R9", 1, 5, 0, 0, 0, 8'h12, 2, 0, 8'h08);
        vec("R9", 1, 5, 0, 0, 0, 8'hFD, 7, 0, 8'h00);

        // R10: idle request with write-like inputs has no effect
        vec("R10", 0, 1, 0, 0, 0, 8'hFE, 0, 8'h77, 8'h00);
        vec("R10", 0, 1, 1, 1, 1, 0, 0, 8'h77, 8'h00);
        vec("R10", 0, 2, 0, 0, 0, 8'hFF, 0, 0, 8'h00);
        rd("R10", 8'hFE); rd("R10", 8'hFC); rd("R10", 8'hFF); rd("R10", 8'hFD);

        @(negedge clk);
        req_valid = 1'b0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule